// File: doc/BRIEF.md
# Dual-Edge 7:1 Serializer Lane

This block is one data lane of a seven-to-one serializer clocked at three and a half times the pixel rate. Each pixel provides a 7-bit parallel word. The lane sends the seven bits out serially as two bit streams. One stream is meant for the rising-edge data input of a double-data-rate output register and the other for its falling-edge data input. Every cycle of the fast clock therefore carries two serial bits, which gives a line rate of seven times the pixel clock.

The word is divided between two half-width shift registers. One is clocked on the rising edge and the other on the falling edge. Because seven bits fill three and a half cycles, the halves change roles from pixel to pixel. In one pixel the rising-edge register sends the even-numbered bits and the falling-edge register sends the odd-numbered bits. In the next pixel the assignment is reversed.

An external sequencer drives three controls:
- a rising-edge load strobe;
- an early falling-edge load strobe, which the lane retimes on the falling edge;
- an even/odd select.

Top module: `dual_edge_ser_lane`

## Requirements
- R1: With the sequencer schedule applied, the lane delivers the bits of each pixel in the order 0 to 6, two bits per cycle (the rising-edge slot first), and consecutive pixels follow with no gap or repeat. The schedule runs over a 7-cycle period p=0..6, and the controls are set for cycle p:
  - load_rise_i is high in p=6 and p=3;
  - preload_fall_i is high in p=6 and p=2;
  - sel_odd_i is 0 in p=6 and p=0, and 1 in p=3;
  - word_i holds pixel A in p=6 and p=0, and pixel B in p=3.
- R2: When load_rise_i is high at a rising edge, the rising-edge register captures a half of word_i. With sel_odd_i=0 it takes bits {0,2,4,6}, with bit 0 at the output. With sel_odd_i=1 it takes bits {1,3,5}, with bit 1 at the output and a zero in the top slot.
- R3: When preload_fall_i is sampled high at the falling edge of cycle c, the falling-edge register loads at the falling edge of cycle c+1. It takes the half opposite to the one sel_odd_i selects: bits {1,3,5} plus a zero when sel_odd_i=0, and bits {0,2,4,6} when sel_odd_i=1. word_i and sel_odd_i are sampled at that falling edge.
- R4: Between loads, each register shifts one place toward its output on each of its own active edges, and a zero enters the top slot.
- R5: At an edge with no load, word_i and sel_odd_i have no effect. Once both registers have drained, both outputs stay 0.
- R6: While rst_ni is low, both shift registers and the retimed falling-edge load flop are cleared, and both outputs read 0.
- R7: bit_rise_o changes only at rising edges and bit_fall_o changes only at falling edges. Each stays stable through the opposite clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serializer clock at 3.5 times the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | WORD_W | Parallel pixel word |
| sel_odd_i | input | 1 | 1: the rising-edge register takes the odd half and the falling-edge register the even half |
| load_rise_i | input | 1 | Load strobe for the rising-edge register |
| preload_fall_i | input | 1 | Early load strobe for the falling-edge register, retimed on the falling edge |
| bit_rise_o | output | 1 | Serial bit for the rising-edge data input of the DDR output register |
| bit_fall_o | output | 1 | Serial bit for the falling-edge data input of the DDR output register |

## Verification
The bench builds the lane with the default WORD_W of 7, so each half register is 4 bits wide. At this width the odd half leaves a zero-padded top slot, and the roles alternate over a 7-cycle, two-pixel period. A model of the DDR output register rebuilds the serial stream and compares it pixel by pixel with the words that were sent. In the cycles where no load occurs, word_i and sel_odd_i are driven with random values, which shows that the lane samples them only at its load edges. The bench also checks that the falling-edge load comes one cycle after its early strobe, and that the outputs settle to zeros once loading stops.

// File: rtl/ser_lane_pkg.sv
package ser_lane_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
endpackage

// File: rtl/ser_half_pick.sv
module ser_half_pick #(
  parameter int WORD_W = 7,
  parameter int HALF_W = (WORD_W + 1) / 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              odd_i,
  output logic [HALF_W-1:0] half_o
);
  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    localparam int EV = 2 * i;
    localparam int OD = 2 * i + 1;
    if (OD < WORD_W) begin : g_pair
      assign half_o[i] = odd_i ? word_i[OD] : word_i[EV];
    end else begin : g_tail
      // odd half is one bit short: pad top slot with zero
      assign half_o[i] = odd_i ? 1'b0 : word_i[EV];
    end
  end
endmodule

// File: rtl/ser_shift_half.sv
module ser_shift_half #(
  parameter int                  HALF_W = 4,
  parameter ser_lane_pkg::edge_e EDGE   = ser_lane_pkg::EDGE_RISE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] data_i,
  output logic              bit_o,
  output logic              nxt_o
);
  logic [HALF_W-1:0] q_q, q_d;

  always_comb q_d = load_i ? data_i : {1'b0, q_q[HALF_W-1:1]};

  if (EDGE == ser_lane_pkg::EDGE_RISE) begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= q_d;
    end
  end else begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= q_d;
    end
  end

  assign bit_o = q_q[0];
  assign nxt_o = q_q[1];
endmodule

// File: rtl/dual_edge_ser_lane.sv
module dual_edge_ser_lane #(
  parameter int WORD_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sel_odd_i,
  input  logic              load_rise_i,
  input  logic              preload_fall_i,
  output logic              bit_rise_o,
  output logic              bit_fall_o
);
  localparam int HALF_W = (WORD_W + 1) / 2;

  logic              load_fall_q;
  logic [HALF_W-1:0] rise_half, fall_half;
  logic              rise_nxt, fall_nxt;

  // early strobe retimed so it is stable a full cycle before use
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_fall_q <= 1'b0;
    else         load_fall_q <= preload_fall_i;
  end

  ser_half_pick #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_pick_rise (
    .word_i (word_i),
    .odd_i  (sel_odd_i),
    .half_o (rise_half)
  );

  ser_half_pick #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_pick_fall (
    .word_i (word_i),
    .odd_i  (~sel_odd_i),
    .half_o (fall_half)
  );

  ser_shift_half #(.HALF_W(HALF_W), .EDGE(ser_lane_pkg::EDGE_RISE)) u_sh_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_rise_i),
    .data_i (rise_half),
    .bit_o  (bit_rise_o),
    .nxt_o  (rise_nxt)
  );

  ser_shift_half #(.HALF_W(HALF_W), .EDGE(ser_lane_pkg::EDGE_FALL)) u_sh_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_fall_q),
    .data_i (fall_half),
    .bit_o  (bit_fall_o),
    .nxt_o  (fall_nxt)
  );
endmodule

// File: rtl/dual_edge_ser_lane_chk.sv
module dual_edge_ser_lane_chk #(
  parameter int WORD_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              sel_odd_i,
  input logic              load_rise_i,
  input logic              preload_fall_i,
  input logic              bit_rise_o,
  input logic              bit_fall_o,
  input logic              rise_nxt_i,
  input logic              fall_nxt_i,
  input logic              load_fall_i
);
  assert_rise_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_rise_i |=> (bit_rise_o == ($past(sel_odd_i) ? $past(word_i[1]) : $past(word_i[0]))));

  assert_rise_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_rise_i |=> (bit_rise_o == $past(rise_nxt_i)));

  assert_fall_load_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    preload_fall_i |-> ##2 (bit_fall_o == ($past(sel_odd_i) ? $past(word_i[0]) : $past(word_i[1]))));

  assert_fall_shift_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !load_fall_i |=> (bit_fall_o == $past(fall_nxt_i)));

  assert_retime_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    preload_fall_i |=> load_fall_i);
endmodule

bind dual_edge_ser_lane dual_edge_ser_lane_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .word_i         (word_i),
  .sel_odd_i      (sel_odd_i),
  .load_rise_i    (load_rise_i),
  .preload_fall_i (preload_fall_i),
  .bit_rise_o     (bit_rise_o),
  .bit_fall_o     (bit_fall_o),
  .rise_nxt_i     (rise_nxt),
  .fall_nxt_i     (fall_nxt),
  .load_fall_i    (load_fall_q)
);

// File: tb/dual_edge_ser_lane_tb.sv
module dual_edge_ser_lane_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 7;
  localparam int N_PAIRS    = 40;
  localparam int N_PIX      = 2 * N_PAIRS;
  localparam int N_IDLE     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] word = '0;
  logic              sel_odd = 1'b0;
  logic              ld_rise = 1'b0;
  logic              pre_fall = 1'b0;
  logic              bit_r, bit_f;

  logic [WORD_W-1:0] pix [N_PIX];
  logic [WORD_W-1:0] rx  [N_PIX];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_edge_ser_lane #(.WORD_W(WORD_W)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .word_i         (word),
    .sel_odd_i      (sel_odd),
    .load_rise_i    (ld_rise),
    .preload_fall_i (pre_fall),
    .bit_rise_o     (bit_r),
    .bit_fall_o     (bit_f)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] directed_pix(input int i);
    case (i)
      0: return 7'h00;
      1: return 7'h7F;
      2: return 7'h55;
      3: return 7'h2A;
      4: return 7'h01;
      5: return 7'h40;
      6: return 7'h7F;
      default: return 7'h00;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic r, f, f_prev;
    void'($urandom(32'd2024));
    for (int i = 0; i < N_PIX; i++)
      pix[i] = (i < 8) ? directed_pix(i) : WORD_W'($urandom);
    for (int i = 0; i < N_PIX; i++) rx[i] = '0;
    f_prev = 1'b0;

    repeat (3) @(posedge clk);
    #3;
    check(bit_r == 1'b0 && bit_f == 1'b0, "R6 reset clears outputs", {bit_r, bit_f}, 0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc <= 7 * N_PAIRS + N_IDLE; cyc++) begin
      int ph, m;
      bit active;
      @(posedge clk);
      #1;
      ph = (cyc + 6) % 7;
      m = cyc / 7;
      active = (m < N_PAIRS);
      ld_rise  = active && (ph == 6 || ph == 3);
      pre_fall = active && (ph == 6 || ph == 2);
      if (active && (ph == 6 || ph == 0)) begin
        word = pix[2*m];
        sel_odd = 1'b0;
      end else if (active && ph == 3) begin
        word = pix[2*m+1];
        sel_odd = 1'b1;
      end else begin
        // unused phases: junk must be ignored (R5)
        word = WORD_W'($urandom);
        sel_odd = 1'($urandom);
      end
      #2;
      r = bit_r;
      if (cyc > 0)
        check(bit_f == f_prev, "R7 fall bit stable in high phase", bit_f, f_prev);
      @(negedge clk);
      #2;
      f = bit_f;
      f_prev = f;
      check(bit_r == r, "R7 rise bit stable in low phase", bit_r, r);
      if (cyc == 0) begin
        check(r == 1'b0 && f == 1'b0, "R6 outputs zero before first load", {r, f}, 0);
      end else if (cyc <= 7 * N_PAIRS) begin
        int k;
        k = 2 * (cyc - 1);
        rx[k/7][k%7] = r;
        rx[(k+1)/7][(k+1)%7] = f;
      end else begin
        check(r == 1'b0 && f == 1'b0, "R5 drained lane stays zero, inputs ignored", {r, f}, 0);
      end
    end

    for (int i = 0; i < N_PIX; i++)
      check(rx[i] == pix[i], "R1/R2/R3/R4 rebuilt pixel word", int'(rx[i]), int'(pix[i]));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule